// File: doc/BRIEF.md
# Timer Channel Capture/Compare Unit

This block is one timer channel. It holds a 16-bit free-running counter, two data registers and a status word. It can run in four modes. Two of them treat the pin as plain digital I/O. The other two capture the counter on an input edge, or drive an output flip-flop when the counter reaches a programmed compare value.

The input pin first passes through a two-stage synchronizer and then an edge detector. One edge-select bit in the control word has a different job in each mode. In capture mode it enables events on both edges. In GPIO input mode it suppresses the flag. In compare mode it makes each match toggle the output.

Software uses a plain address/write-data port with a registered read-data output. The status bits are sticky and cleared by writing 1. The flag is also driven on a dedicated output pin.

Top module: `tcc_channel`

## Requirements
- R1: After synchronous reset, every register reads 0, `out_pin` is 0 and `flag_o` is 0.
- R2: Register map (`addr`): 0 = control, 1 = status, 2 = counter, 3 = data A, 4 = data B.
  - Control bits: [1:0] mode (00 GPIO input, 01 GPIO output, 10 input capture, 11 output compare), [2] edge select, [3] edge polarity.
  - Status bits: [0] flag, [1] overrun, [2] overflow, [3] synchronized pin level, [4] output level.
  - `rdata` shows the register selected by `addr` one clock later.
- R3: With edge select 0, only a rising pin edge counts as an event when polarity is 1, and only a falling edge counts when polarity is 0. A pin change is seen as an edge on the third rising clock edge after it.
- R4: In GPIO input mode, edge select 1 suppresses every flag. Status bit 3 always shows the synchronized pin level.
- R5: In input capture mode, edge select 1 makes both edges events. Each event copies the counter into data A. A pin change made right after a counter load of V captures V+2.
- R6: The counter adds 1 every clock in capture and compare modes and holds in the GPIO modes. A write to address 2 loads it.
- R7: A counter wrap from 0xFFFF to 0 sets the overflow bit and leaves the flag alone.
- R8: In compare mode with edge select 0, a counter match with data A drives the output to the polarity bit and sets the flag.
- R9: In compare mode with edge select 1, every match toggles the output.
- R10: In GPIO output mode, the output takes the polarity bit on the next clock, and no flag is raised.
- R11: Writing 1 to status bits 0 to 2 clears the corresponding bit. Writing 0 to a bit leaves it unchanged.
- R12: An event that arrives while the flag is already set sets the overrun bit.
- R13: An event in the same cycle as a write-1 clear of the flag leaves the flag set.
- R14: `flag_o` always equals the status flag bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_pin | input | 1 | Asynchronous channel input pin |
| addr | input | 3 | Register address |
| wr_en | input | 1 | Write strobe |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Registered read data |
| out_pin | output | 1 | Output flip-flop |
| flag_o | output | 1 | Channel flag |

## Verification
The assertions assume that `in_pin` stays stable long enough for the synchronizer to pass each level. They also assume that software does not load the counter with the compare value in the same cycle that a match is expected. The stimulus holds each pin level for at least four clocks before it changes the pin again. It loads the counter only well away from data A, except in the one directed test where a match is meant to coincide with a flag clear.

// File: rtl/tcc_pkg.sv
package tcc_pkg;
  typedef enum logic [1:0] {
    MODE_GPIN  = 2'b00,
    MODE_GPOUT = 2'b01,
    MODE_CAP   = 2'b10,
    MODE_CMP   = 2'b11
  } tcc_mode_e;

  localparam logic [2:0] ADDR_CTRL = 3'd0;
  localparam logic [2:0] ADDR_STAT = 3'd1;
  localparam logic [2:0] ADDR_CNT  = 3'd2;
  localparam logic [2:0] ADDR_DA   = 3'd3;
  localparam logic [2:0] ADDR_DB   = 3'd4;

  localparam int BIT_FLAG = 0;
  localparam int BIT_OVR  = 1;
  localparam int BIT_OVFL = 2;
  localparam int BIT_LVL  = 3;
  localparam int BIT_OUT  = 4;
endpackage

// File: rtl/tcc_edge_det.sv
module tcc_edge_det #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  output logic lvl,
  output logic rise,
  output logic fall
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic prev_q;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= pin;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= {sync_q[SYNC_STAGES-2:0], pin};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= sync_q[SYNC_STAGES-1];
  end

  assign lvl  = sync_q[SYNC_STAGES-1];
  assign rise = lvl & ~prev_q;
  assign fall = ~lvl & prev_q;
endmodule

// File: rtl/tcc_counter.sv
module tcc_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] cnt,
  output logic         wrap
);
  localparam logic [W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (load) cnt <= load_val;
    else if (en)   cnt <= cnt + 1'b1;
  end

  assign wrap = en && !load && (cnt == CNT_MAX);
endmodule

// File: rtl/tcc_status.sv
module tcc_status (
  input  logic       clk,
  input  logic       rst,
  input  logic       evt,
  input  logic       ovf_evt,
  input  logic [2:0] clr,
  output logic       flag,
  output logic       ovr,
  output logic       ovfl
);
  always_ff @(posedge clk) begin
    if (rst) begin
      flag <= 1'b0;
      ovr  <= 1'b0;
      ovfl <= 1'b0;
    end else begin
      flag <= evt | (flag & ~clr[0]);
      ovr  <= (evt & flag) | (ovr & ~clr[1]);
      ovfl <= ovf_evt | (ovfl & ~clr[2]);
    end
  end
endmodule

// File: rtl/tcc_channel.sv
module tcc_channel
  import tcc_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_pin,
  input  logic [2:0]       addr,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] rdata,
  output logic             out_pin,
  output logic             flag_o
);
  tcc_mode_e        mode_q;
  logic             sel_q, pol_q;
  logic [CNT_W-1:0] da_q, db_q, cnt;
  logic             lvl, rise, fall, wrap;
  logic             flag_q, ovr_q, ovfl_q;
  logic             cnt_en, cnt_load, edge_hit;
  logic             gpin_evt, cap_evt, cmp_match, chan_evt;
  logic [2:0]       clr_mask;
  logic             wr_ctrl, wr_da, wr_db;

  tcc_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst(rst), .pin(in_pin), .lvl(lvl), .rise(rise), .fall(fall)
  );

  assign cnt_en   = (mode_q == MODE_CAP) || (mode_q == MODE_CMP);
  assign cnt_load = wr_en && (addr == ADDR_CNT);

  tcc_counter #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .en(cnt_en), .load(cnt_load), .load_val(wdata),
    .cnt(cnt), .wrap(wrap)
  );

  assign edge_hit  = sel_q ? (rise | fall) : (pol_q ? rise : fall);
  assign gpin_evt  = (mode_q == MODE_GPIN) && !sel_q && (pol_q ? rise : fall);
  assign cap_evt   = (mode_q == MODE_CAP) && edge_hit;
  assign cmp_match = (mode_q == MODE_CMP) && (cnt == da_q);
  assign chan_evt  = gpin_evt | cap_evt | cmp_match;

  assign clr_mask = (wr_en && (addr == ADDR_STAT)) ? wdata[2:0] : 3'b000;

  tcc_status u_stat (
    .clk(clk), .rst(rst), .evt(chan_evt), .ovf_evt(wrap), .clr(clr_mask),
    .flag(flag_q), .ovr(ovr_q), .ovfl(ovfl_q)
  );

  assign wr_ctrl = wr_en && (addr == ADDR_CTRL);
  assign wr_da   = wr_en && (addr == ADDR_DA);
  assign wr_db   = wr_en && (addr == ADDR_DB);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= MODE_GPIN;
      sel_q  <= 1'b0;
      pol_q  <= 1'b0;
    end else if (wr_ctrl) begin
      mode_q <= tcc_mode_e'(wdata[1:0]);
      sel_q  <= wdata[2];
      pol_q  <= wdata[3];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      da_q <= '0;
      db_q <= '0;
    end else begin
      if (cap_evt)    da_q <= cnt;
      else if (wr_da) da_q <= wdata;
      if (wr_db)      db_q <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_pin <= 1'b0;
    end else if (mode_q == MODE_GPOUT) begin
      out_pin <= pol_q;
    end else if (cmp_match) begin
      out_pin <= sel_q ? ~out_pin : pol_q;
    end
  end

  logic [CNT_W-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    case (addr)
      ADDR_CTRL: begin
        rd_mux[1:0] = mode_q;
        rd_mux[2]   = sel_q;
        rd_mux[3]   = pol_q;
      end
      ADDR_STAT: begin
        rd_mux[BIT_FLAG] = flag_q;
        rd_mux[BIT_OVR]  = ovr_q;
        rd_mux[BIT_OVFL] = ovfl_q;
        rd_mux[BIT_LVL]  = lvl;
        rd_mux[BIT_OUT]  = out_pin;
      end
      ADDR_CNT: rd_mux = cnt;
      ADDR_DA:  rd_mux = da_q;
      ADDR_DB:  rd_mux = db_q;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_mux;
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/tcc_channel_chk.sv
module tcc_channel_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             evt,
  input logic             cap_evt,
  input logic             wrap,
  input logic             flag,
  input logic             ovr,
  input logic             ovfl,
  input logic [2:0]       clr,
  input logic [1:0]       mode,
  input logic             sel,
  input logic             pol,
  input logic             out_pin,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] da
);
  // R12
  overrun_set_chk: assert property (@(posedge clk) disable iff (rst)
    (evt && flag) |=> ovr);

  // R13
  event_wins_chk: assert property (@(posedge clk) disable iff (rst)
    evt |=> flag);

  // R11
  flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (flag && !evt && !clr[0]) |=> flag);

  // R7
  overflow_set_chk: assert property (@(posedge clk) disable iff (rst)
    wrap |=> ovfl);

  // R10
  gpout_level_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b01) |=> (out_pin == $past(pol)));

  // R5
  capture_copy_chk: assert property (@(posedge clk) disable iff (rst)
    cap_evt |=> (da == $past(cnt)));

  // R4
  gpin_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b00 && sel && !flag) |=> !flag);
endmodule

bind tcc_channel tcc_channel_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .evt(chan_evt), .cap_evt(cap_evt), .wrap(wrap),
  .flag(flag_q), .ovr(ovr_q), .ovfl(ovfl_q), .clr(clr_mask),
  .mode(mode_q), .sel(sel_q), .pol(pol_q), .out_pin(out_pin),
  .cnt(cnt), .da(da_q)
);

// File: tb/tb_tcc_channel.sv
module tb_tcc_channel;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_pin;
  logic [2:0]  addr;
  logic        wr_en;
  logic [15:0] wdata;
  logic [15:0] rdata;
  logic        out_pin;
  logic        flag_o;

  int tests_run = 0;
  int tests_failed = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  tcc_channel dut (
    .clk(clk), .rst(rst), .in_pin(in_pin), .addr(addr), .wr_en(wr_en),
    .wdata(wdata), .rdata(rdata), .out_pin(out_pin), .flag_o(flag_o)
  );

  // vector: [5:4] mode, [3] edge select, [2] polarity, [1] rising edge, [0] expected flag
  localparam logic [5:0] VEC [16] = '{
    6'b00_0111, 6'b00_0100, 6'b00_0010, 6'b00_0001,
    6'b00_1110, 6'b00_1100, 6'b00_1010, 6'b00_1000,
    6'b10_0111, 6'b10_0100, 6'b10_0010, 6'b10_0001,
    6'b10_1111, 6'b10_1101, 6'b10_1011, 6'b10_1001
  };

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    tests_run++;
    if (got !== exp) begin
      tests_failed++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    addr = a;
    @(negedge clk);
    d = rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
      $finish;
    end
  endtask

  initial begin
    for (int c = 0; c < 150000; c++) @(posedge clk);
    tests_run++;
    tests_failed++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [15:0] v;
    rst = 1'b1; in_pin = 1'b0; addr = '0; wr_en = 1'b0; wdata = '0;
    idle(3);
    rst = 1'b0;
    @(negedge clk);
    check("R1 out_pin", {15'b0, out_pin}, 16'h0);
    check("R1 flag_o", {15'b0, flag_o}, 16'h0);
    rd(3'd0, v); check("R1 ctrl", v, 16'h0);
    rd(3'd1, v); check("R1 status", v, 16'h0);
    rd(3'd2, v); check("R1 counter", v, 16'h0);
    rd(3'd3, v); check("R1 data A", v, 16'h0);

    // table: edge policy in GPIO input and capture modes
    for (int k = 0; k < 16; k++) begin
      logic [5:0] e;
      e = VEC[k];
      wr(3'd0, {12'b0, e[2], e[3], e[5:4]});
      in_pin = ~e[1];
      idle(5);
      wr(3'd1, 16'h0007);
      in_pin = e[1];
      idle(5);
      rd(3'd1, v);
      check($sformatf("R3 R4 R5 vec%0d flag", k), {15'b0, v[0]}, {15'b0, e[0]});
      check($sformatf("R14 vec%0d flag_o", k), {15'b0, flag_o}, {15'b0, e[0]});
      if (e[5:4] == 2'b00)
        check($sformatf("R4 vec%0d level", k), {15'b0, v[3]}, {15'b0, e[1]});
    end

    // R2 data B storage
    wr(3'd4, 16'hBEEF);
    rd(3'd4, v); check("R2 data B", v, 16'hBEEF);

    // R6 counter holds in GPIO input mode, loads on write
    wr(3'd0, 16'h0000);
    wr(3'd2, 16'h0055);
    idle(10);
    rd(3'd2, v); check("R6 counter hold", v, 16'h0055);

    // R5 capture value
    wr(3'd0, 16'h0006); // capture, both edges
    in_pin = 1'b0;
    idle(5);
    wr(3'd1, 16'h0007);
    wr(3'd2, 16'h1230);
    in_pin = 1'b1;
    idle(6);
    rd(3'd3, v); check("R5 captured value", v, 16'h1232);

    // R6 counter load read-back in a counting mode
    wr(3'd2, 16'h0100);
    rd(3'd2, v); check("R6 counter load", v, 16'h0100);

    // R7 overflow
    wr(3'd3, 16'h8000);
    wr(3'd0, 16'h0003); // compare, sel 0, pol 0
    wr(3'd1, 16'h0007);
    wr(3'd2, 16'hFFFD);
    idle(6);
    rd(3'd1, v);
    check("R7 overflow set", {15'b0, v[2]}, 16'h1);
    check("R7 flag untouched", {15'b0, v[0]}, 16'h0);
    wr(3'd1, 16'h0004);
    rd(3'd1, v); check("R11 overflow cleared", {15'b0, v[2]}, 16'h0);

    // R8 compare drives polarity level
    wr(3'd3, 16'h0040);
    wr(3'd0, 16'h000B); // compare, pol 1
    wr(3'd1, 16'h0007);
    wr(3'd2, 16'h0030);
    idle(30);
    check("R8 out high", {15'b0, out_pin}, 16'h1);
    rd(3'd1, v); check("R8 flag", {15'b0, v[0]}, 16'h1);
    wr(3'd0, 16'h0003); // pol 0
    wr(3'd2, 16'h0030);
    idle(30);
    check("R8 out low", {15'b0, out_pin}, 16'h0);

    // R9 toggle
    wr(3'd0, 16'h0007); // compare, sel 1
    wr(3'd2, 16'h0030);
    idle(30);
    check("R9 first toggle", {15'b0, out_pin}, 16'h1);
    wr(3'd2, 16'h0030);
    idle(30);
    check("R9 second toggle", {15'b0, out_pin}, 16'h0);

    // R13 match and clear in the same cycle
    wr(3'd1, 16'h0007);
    wr(3'd3, 16'h0203);
    wr(3'd2, 16'h0200);
    idle(3);
    wr(3'd1, 16'h0001);
    rd(3'd1, v); check("R13 event wins", {15'b0, v[0]}, 16'h1);

    // R10 GPIO output
    wr(3'd1, 16'h0007);
    wr(3'd0, 16'h0009); // GPIO out, pol 1
    idle(2);
    check("R10 out follows pol", {15'b0, out_pin}, 16'h1);
    rd(3'd1, v);
    check("R10 no flag", {15'b0, v[0]}, 16'h0);
    check("R2 output level bit", {15'b0, v[4]}, 16'h1);
    wr(3'd0, 16'h0001);
    idle(2);
    check("R10 out low", {15'b0, out_pin}, 16'h0);

    // R12 overrun and R11 selective clear
    wr(3'd0, 16'h0008); // GPIO in, rising
    in_pin = 1'b0;
    idle(5);
    wr(3'd1, 16'h0007);
    in_pin = 1'b1; idle(5);
    in_pin = 1'b0; idle(5);
    in_pin = 1'b1; idle(5);
    rd(3'd1, v); check("R12 overrun", v[1:0], 2'b11);
    wr(3'd1, 16'h0002);
    rd(3'd1, v); check("R11 write 0 keeps flag", v[1:0], 2'b01);
    wr(3'd1, 16'h0001);
    rd(3'd1, v); check("R11 flag cleared", v[1:0], 2'b00);
    check("R14 flag_o low", {15'b0, flag_o}, 16'h0);

    finish_run();
  end
endmodule